// File: doc/BRIEF.md
# Process-Tagged Translation Lookaside Buffer

This block caches recent virtual-to-physical page translations. A lookup carries a virtual page number, the requesting process identifier, the page offset and an access kind. Every stored entry is compared with the request at once. A valid entry whose page number and process identifier both match, and whose permissions allow the access, yields its frame number and the physical address in the same cycle. The physical address is the frame number with the offset appended.

When nothing matches, the block raises a miss. An outside agent then walks the page tables and presents the translation on the refill port. The refill goes into a free slot if one exists. Otherwise it replaces the entry that was used least recently. Software can remove one translation, selected by page and process, after it edits a page table entry. It can also clear the whole buffer. Because entries carry a process tag, a context switch does not need to clear the buffer.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is invalid, so any lookup reports a miss.
- R2: A lookup that matches a valid entry with a permitted access raises `hit` in the same cycle. It drives `pfn` and `perm` from that entry and drives `paddr` = {pfn, lk_off}.
- R3: A lookup that matches no valid entry raises `miss` with `hit` and `prot_fault` low. While `hit` is low, `paddr`, `pfn` and `perm` are zero.
- R4: An entry matches only if its stored process identifier equals `lk_pid`. The same page number may be held for several processes at once, each with its own frame.
- R5: Permission bits are bit0 read, bit1 write and bit2 execute. Access codes are 0 read, 1 write and 2 execute; code 3 is never permitted. A match whose permission bit is clear raises `prot_fault` instead of `hit`, with `miss` low and `paddr` zero.
- R6: A refill presented with `fill_en` at a rising edge can be looked up from the next cycle on.
- R7: A refill goes into an invalid slot, the lowest-indexed one, whenever any slot is invalid. No valid translation is lost in that case.
- R8: When all slots are valid, a refill replaces the entry least recently touched. Only permitted hits and refills count as touches.
- R9: `inv_en` removes only the entry matching both `inv_vpn` and `inv_pid`. Other processes' entries for the same page stay.
- R10: `flush` makes every entry invalid.
- R11: While `flush` or `inv_en` is high, the lookup outputs `hit`, `miss` and `prot_fault` are all low and any refill in that cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_en | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_pid | input | PID_W | Process identifier of the request |
| lk_off | input | OFF_W | Page offset, passed through to the address |
| lk_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| hit | output | 1 | Permitted translation found |
| miss | output | 1 | No matching entry |
| prot_fault | output | 1 | Entry found but access not permitted |
| pfn | output | PFN_W | Frame number on hit |
| perm | output | 3 | Permission bits of the hit entry |
| paddr | output | PFN_W+OFF_W | Physical address on hit |
| fill_en | input | 1 | Install a translation |
| fill_vpn | input | VPN_W | Page number of the refill |
| fill_pid | input | PID_W | Process identifier of the refill |
| fill_pfn | input | PFN_W | Frame number of the refill |
| fill_perm | input | 3 | Permission bits of the refill |
| inv_en | input | 1 | Remove one translation |
| inv_vpn | input | VPN_W | Page number to remove |
| inv_pid | input | PID_W | Process identifier to remove |
| flush | input | 1 | Invalidate every entry |

## Verification
Lookup results are combinational. `hit`, `miss`, `prot_fault`, `pfn` and `paddr` settle in the same cycle the request is driven. The bench drives each request on a falling edge and samples one nanosecond later, before the next rising edge. Refill, invalidate and flush change the table on the next rising edge. Each scenario task therefore holds those commands for exactly one rising edge and makes its next lookup on the following falling edge. At that point the new state is the one under test. The recency order also moves only on rising edges. The eviction checks therefore count which hits and refills were accepted before each refill.

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int PID_W   = 8,
  parameter int OFF_W   = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lk_en,
  input  logic [VPN_W-1:0]       lk_vpn,
  input  logic [PID_W-1:0]       lk_pid,
  input  logic [OFF_W-1:0]       lk_off,
  input  logic [1:0]             lk_acc,
  output logic                   hit,
  output logic                   miss,
  output logic                   prot_fault,
  output logic [PFN_W-1:0]       pfn,
  output logic [2:0]             perm,
  output logic [PFN_W+OFF_W-1:0] paddr,
  input  logic                   fill_en,
  input  logic [VPN_W-1:0]       fill_vpn,
  input  logic [PID_W-1:0]       fill_pid,
  input  logic [PFN_W-1:0]       fill_pfn,
  input  logic [2:0]             fill_perm,
  input  logic                   inv_en,
  input  logic [VPN_W-1:0]       inv_vpn,
  input  logic [PID_W-1:0]       inv_pid,
  input  logic                   flush
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] vld;
  logic [VPN_W-1:0]   t_vpn  [ENTRIES];
  logic [PID_W-1:0]   t_pid  [ENTRIES];
  logic [PFN_W-1:0]   t_pfn  [ENTRIES];
  logic [2:0]         t_perm [ENTRIES];
  logic [IDX_W-1:0]   age    [ENTRIES];

  logic [ENTRIES-1:0] lk_match, inv_match;
  logic [IDX_W-1:0]   h_idx, v_idx, t_idx;
  logic               free_slot, allowed, found, busy, do_fill, touch;
  logic [2:0]         sel_perm;

  always_comb begin
    lk_match  = '0;
    inv_match = '0;
    h_idx     = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      lk_match[i]  = vld[i] && t_vpn[i] == lk_vpn  && t_pid[i] == lk_pid;
      inv_match[i] = vld[i] && t_vpn[i] == inv_vpn && t_pid[i] == inv_pid;
      if (lk_match[i]) h_idx = IDX_W'(i);
    end
  end

  assign sel_perm = t_perm[h_idx];

  always_comb begin
    case (lk_acc)
      2'd0:    allowed = sel_perm[0];
      2'd1:    allowed = sel_perm[1];
      2'd2:    allowed = sel_perm[2];
      default: allowed = 1'b0;
    endcase
  end

  assign busy       = flush | inv_en;
  assign found      = lk_en & ~busy & (|lk_match);
  assign hit        = found & allowed;
  assign prot_fault = found & ~allowed;
  assign miss       = lk_en & ~busy & ~(|lk_match);
  assign pfn        = hit ? t_pfn[h_idx] : '0;
  assign perm       = hit ? sel_perm : '0;
  assign paddr      = hit ? {t_pfn[h_idx], lk_off} : '0;

  always_comb begin
    free_slot = 1'b0;
    v_idx     = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        v_idx     = IDX_W'(i);
        free_slot = 1'b1;
      end
    end
    if (!free_slot) begin
      for (int i = 0; i < ENTRIES; i++)
        if (age[i] == OLDEST) v_idx = IDX_W'(i);
    end
  end

  assign do_fill = fill_en & ~busy;
  assign touch   = do_fill | hit;
  assign t_idx   = do_fill ? v_idx : h_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      for (int i = 0; i < ENTRIES; i++) age[i] <= IDX_W'(i);
    end else if (flush) begin
      vld <= '0;
    end else if (inv_en) begin
      vld <= vld & ~inv_match;
    end else begin
      if (do_fill) begin
        vld[v_idx]    <= 1'b1;
        t_vpn[v_idx]  <= fill_vpn;
        t_pid[v_idx]  <= fill_pid;
        t_pfn[v_idx]  <= fill_pfn;
        t_perm[v_idx] <= fill_perm;
      end
      if (touch) begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (IDX_W'(i) == t_idx)   age[i] <= '0;
          else if (age[i] < age[t_idx]) age[i] <= age[i] + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int VPN_W = 20,
  parameter int PFN_W = 20,
  parameter int PID_W = 8,
  parameter int OFF_W = 12
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   lk_en,
  input logic [VPN_W-1:0]       lk_vpn,
  input logic [PID_W-1:0]       lk_pid,
  input logic [OFF_W-1:0]       lk_off,
  input logic                   fill_en,
  input logic [VPN_W-1:0]       fill_vpn,
  input logic [PID_W-1:0]       fill_pid,
  input logic                   inv_en,
  input logic                   flush,
  input logic                   hit,
  input logic                   miss,
  input logic                   prot_fault,
  input logic [PFN_W+OFF_W-1:0] paddr
);
  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_en && !flush && !inv_en) |-> $countones({hit, miss, prot_fault}) == 1); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_en |-> !hit && !miss && !prot_fault); // R3

  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> paddr[OFF_W-1:0] == lk_off); // R2

  AST_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> paddr == '0); // R3

  AST_FILL_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(fill_en && !flush && !inv_en) && lk_en && !flush && !inv_en
     && lk_vpn == $past(fill_vpn) && lk_pid == $past(fill_pid)) |-> (hit || prot_fault)); // R6

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(flush) && lk_en && !flush && !inv_en) |-> miss); // R10

  AST_CMD_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (flush || inv_en) |-> !hit && !miss && !prot_fault); // R11
endmodule

bind xlat_cache xlat_cache_chk #(
  .VPN_W(VPN_W), .PFN_W(PFN_W), .PID_W(PID_W), .OFF_W(OFF_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_en(lk_en), .lk_vpn(lk_vpn), .lk_pid(lk_pid),
  .lk_off(lk_off), .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pid(fill_pid),
  .inv_en(inv_en), .flush(flush), .hit(hit), .miss(miss),
  .prot_fault(prot_fault), .paddr(paddr)
);

// File: tb/sim_xlat_cache.sv
module sim_xlat_cache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_en = 1'b0, fill_en = 1'b0, inv_en = 1'b0, flush = 1'b0;
  logic [19:0] lk_vpn = '0, fill_vpn = '0, inv_vpn = '0, fill_pfn = '0;
  logic [7:0]  lk_pid = '0, fill_pid = '0, inv_pid = '0;
  logic [11:0] lk_off = 12'hABC;
  logic [1:0]  lk_acc = '0;
  logic [2:0]  fill_perm = '0;
  logic        hit, miss, prot_fault;
  logic [19:0] pfn;
  logic [2:0]  perm;
  logic [31:0] paddr;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  xlat_cache u0 (
    .clk(clk), .rst_n(rst_n), .lk_en(lk_en), .lk_vpn(lk_vpn), .lk_pid(lk_pid),
    .lk_off(lk_off), .lk_acc(lk_acc), .hit(hit), .miss(miss), .prot_fault(prot_fault),
    .pfn(pfn), .perm(perm), .paddr(paddr), .fill_en(fill_en), .fill_vpn(fill_vpn),
    .fill_pid(fill_pid), .fill_pfn(fill_pfn), .fill_perm(fill_perm), .inv_en(inv_en),
    .inv_vpn(inv_vpn), .inv_pid(inv_pid), .flush(flush)
  );

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic look(input string rq, input logic [19:0] v, input logic [7:0] p, input logic [1:0] a,
                      input bit eh, input bit em, input bit ef, input logic [19:0] epfn);
    lk_en = 1'b1; lk_vpn = v; lk_pid = p; lk_acc = a;
    #1;
    chk(rq, "hit", 32'(hit), 32'(eh));
    chk(rq, "miss", 32'(miss), 32'(em));
    chk(rq, "prot_fault", 32'(prot_fault), 32'(ef));
    chk(rq, "paddr", paddr, eh ? {epfn, lk_off} : 32'h0);
    @(negedge clk); lk_en = 1'b0;
  endtask

  task automatic fill(input logic [19:0] v, input logic [7:0] p, input logic [19:0] f, input logic [2:0] pm);
    fill_en = 1'b1; fill_vpn = v; fill_pid = p; fill_pfn = f; fill_perm = pm;
    @(negedge clk); fill_en = 1'b0;
  endtask

  task automatic inval(input logic [19:0] v, input logic [7:0] p);
    inv_en = 1'b1; inv_vpn = v; inv_pid = p;
    @(negedge clk); inv_en = 1'b0;
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic fill_all;
    for (int i = 0; i < 16; i++) fill(20'h100 + 20'(i), 8'd1, 20'h500 + 20'(i), 3'b111);
  endtask

  task automatic t_reset;
    do_reset();
    look("R1", 20'h0, 8'd0, 2'd0, 0, 1, 0, 20'h0);
    look("R1", 20'h100, 8'd1, 2'd0, 0, 1, 0, 20'h0);
  endtask

  task automatic t_hits;
    do_reset();
    fill_all();
    for (int i = 0; i < 16; i++) look("R2", 20'h100 + 20'(i), 8'd1, 2'd0, 1, 0, 0, 20'h500 + 20'(i));
    lk_en = 1'b1; lk_vpn = 20'h10A; lk_pid = 8'd1; lk_acc = 2'd1; #1;
    chk("R2", "pfn", 32'(pfn), 32'h50A);
    chk("R2", "perm", 32'(perm), 32'h7);
    @(negedge clk); lk_en = 1'b0;
    look("R3", 20'h999, 8'd1, 2'd0, 0, 1, 0, 20'h0);
  endtask

  task automatic t_lru;
    do_reset();
    fill_all();
    look("R8", 20'h100, 8'd1, 2'd0, 1, 0, 0, 20'h500);
    fill(20'h200, 8'd1, 20'h600, 3'b111);
    look("R8", 20'h101, 8'd1, 2'd0, 0, 1, 0, 20'h0);
    look("R8", 20'h100, 8'd1, 2'd0, 1, 0, 0, 20'h500);
    look("R6", 20'h200, 8'd1, 2'd0, 1, 0, 0, 20'h600);
    fill(20'h201, 8'd1, 20'h601, 3'b111);
    look("R8", 20'h102, 8'd1, 2'd0, 0, 1, 0, 20'h0);
    look("R8", 20'h103, 8'd1, 2'd0, 1, 0, 0, 20'h503);
    look("R6", 20'h201, 8'd1, 2'd0, 1, 0, 0, 20'h601);
  endtask

  task automatic t_free_first;
    do_reset();
    fill_all();
    inval(20'h105, 8'd1);
    look("R9", 20'h105, 8'd1, 2'd0, 0, 1, 0, 20'h0);
    fill(20'h300, 8'd1, 20'h700, 3'b111);
    for (int i = 0; i < 16; i++)
      if (i != 5) look("R7", 20'h100 + 20'(i), 8'd1, 2'd0, 1, 0, 0, 20'h500 + 20'(i));
    look("R7", 20'h300, 8'd1, 2'd0, 1, 0, 0, 20'h700);
  endtask

  task automatic t_pid;
    do_reset();
    fill(20'h50, 8'd1, 20'h111, 3'b111);
    fill(20'h50, 8'd2, 20'h222, 3'b111);
    look("R4", 20'h50, 8'd1, 2'd0, 1, 0, 0, 20'h111);
    look("R4", 20'h50, 8'd2, 2'd0, 1, 0, 0, 20'h222);
    look("R4", 20'h50, 8'd3, 2'd0, 0, 1, 0, 20'h0);
    inval(20'h50, 8'd1);
    look("R9", 20'h50, 8'd1, 2'd0, 0, 1, 0, 20'h0);
    look("R9", 20'h50, 8'd2, 2'd0, 1, 0, 0, 20'h222);
  endtask

  task automatic t_perm;
    do_reset();
    fill(20'h60, 8'd1, 20'h333, 3'b101);
    look("R5", 20'h60, 8'd1, 2'd0, 1, 0, 0, 20'h333);
    look("R5", 20'h60, 8'd1, 2'd1, 0, 0, 1, 20'h0);
    look("R5", 20'h60, 8'd1, 2'd2, 1, 0, 0, 20'h333);
    look("R5", 20'h60, 8'd1, 2'd3, 0, 0, 1, 20'h0);
  endtask

  task automatic t_flush_prio;
    do_reset();
    fill(20'h70, 8'd1, 20'h444, 3'b111);
    fill(20'h71, 8'd1, 20'h445, 3'b111);
    inv_en = 1'b1; inv_vpn = 20'h71; inv_pid = 8'd1;
    look("R11", 20'h70, 8'd1, 2'd0, 0, 0, 0, 20'h0);
    inv_en = 1'b0;
    look("R9", 20'h70, 8'd1, 2'd0, 1, 0, 0, 20'h444);
    look("R9", 20'h71, 8'd1, 2'd0, 0, 1, 0, 20'h0);
    flush = 1'b1; fill_en = 1'b1; fill_vpn = 20'h80; fill_pid = 8'd1; fill_pfn = 20'h555; fill_perm = 3'b111;
    look("R11", 20'h70, 8'd1, 2'd0, 0, 0, 0, 20'h0);
    flush = 1'b0; fill_en = 1'b0;
    look("R10", 20'h70, 8'd1, 2'd0, 0, 1, 0, 20'h0);
    look("R11", 20'h80, 8'd1, 2'd0, 0, 1, 0, 20'h0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_hits();
    t_lru();
    t_free_first();
    t_pid();
    t_perm();
    t_flush_prio();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule